// File: doc/BRIEF.md
# Vibration Motor Drive Enable Controller

This block is the digital control core of a vibration motor driver whose motor runs for as long as a single enable pin is held high. No PWM stream is involved. It combines the enable pin with three control bits and with digital flags from the analog side: supply valid, regulator output valid and over-temperature. From these it produces the command for the differential output stage. The command is one of four states: off, waking, normal drive, or over-drive with one output tied to the supply rail.

A cycle counter sets the wake-up delay and the shutdown delay. The wake-up time lets the regulator settle before the motor sees voltage. The shutdown time filters short low pulses on the enable pin. A power-down bit or a fault removes drive at once, without waiting for the shutdown delay. The block also assembles the read-only status byte from the synchronized flags. The register file and the serial interface sit outside the block. Fault shutdown therefore never touches the control value, and drive resumes after the fault clears without any reprogramming.

Top module: `erm_drive_ctrl`

## Requirements
- R1: After reset, `drive_state` is OFF (2'b00), `ldo_en` is 0, `od_side` is 0 and `status` is 8'h0E.
- R2: The drive states are encoded OFF=2'b00, WAKING=2'b01, DRIVE=2'b10 and ODRIVE=2'b11. Suppose `en_pin` rises while `ctl0[7]` is 1 and no fault is present. Three clock edges later the state is WAKING. After WAKE_CYC further edges it is DRIVE.
- R3: Suppose `en_pin` falls while the state is DRIVE or ODRIVE. The state becomes OFF SHUT_CYC+2 edges after the fall. A low pulse on `en_pin` that ends before this delay expires leaves drive running. A fall during WAKING returns the state to OFF without reaching DRIVE.
- R4: `ldo_en` is 1 in every state except OFF.
- R5: While the state is DRIVE, setting `ctl0[6]` enters ODRIVE on the next edge. Clearing `ctl0[6]` returns the state to DRIVE. In ODRIVE, `od_side` equals `ctl0[5]` (1 = positive output to the rail, 0 = negative output to the rail). Outside ODRIVE, `od_side` is 0.
- R6: `ctl0[7]` = 0 (power-down) forces OFF on the next edge from any state and prevents any wake-up while the enable pin is high.
- R7: `status` reads {4'b0000, supply valid, regulator valid, not over-temperature, 1'b0}.
- R8: A raised `ot_flag` forces OFF three edges after it rises, with no shutdown delay. After the flag clears, a still-high enable pin starts a new wake-up.
- R9: A low `uv_ok` (supply below the under-voltage threshold) forces OFF three edges after it falls. Wake-up is blocked while it stays low.
- R10: `en_pin`, `uv_ok`, `ldo_ok` and `ot_flag` each pass through two flops before use. A flag change appears in `status` two edges after it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Motor enable pin, asynchronous |
| ctl0 | input | 8 | Control value: bit 7 power enable, bit 6 over-drive enable, bit 5 over-drive side |
| uv_ok | input | 1 | Supply above under-voltage threshold, asynchronous |
| ldo_ok | input | 1 | Regulator output valid, asynchronous |
| ot_flag | input | 1 | Over-temperature tripped, asynchronous |
| drive_state | output | 2 | Output stage command |
| od_side | output | 1 | Over-drive rail side select |
| ldo_en | output | 1 | Regulator enable |
| status | output | 8 | Read-only status byte |

## Verification
A wrong wake-up or shutdown count shows at the ports as a change of `drive_state` one or more cycles away from the edge that R2 or R3 predicts. The bench therefore samples the cycle before each transition and the cycle of the transition itself. A fault or power-down path that waits for the shutdown counter would keep DRIVE visible past the third edge after the flag changes. A status bit in the wrong position or with the wrong polarity shows two edges after its flag changes.

// File: rtl/erm_pkg.sv
package erm_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'b00,
    ST_WAKING = 2'b01,
    ST_DRIVE  = 2'b10,
    ST_ODRIVE = 2'b11
  } drv_state_e;

  localparam int CTL_PWR_BIT  = 7;
  localparam int CTL_OD_BIT   = 6;
  localparam int CTL_SIDE_BIT = 5;
  localparam int STATUS_W     = 8;
endpackage

// File: rtl/erm_sync.sv
module erm_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/erm_status_pack.sv
module erm_status_pack
  import erm_pkg::*;
(
  input  logic                supply_ok,
  input  logic                reg_ok,
  input  logic                ot_trip,
  output logic [STATUS_W-1:0] status
);
  always_comb begin
    status    = '0;
    status[3] = supply_ok;
    status[2] = reg_ok;
    status[1] = ~ot_trip;
  end
endmodule

// File: rtl/erm_drive_fsm.sv
module erm_drive_fsm
  import erm_pkg::*;
#(
  parameter int WAKE_CYC = 12500,
  parameter int SHUT_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s,
  input  logic       pwr_bit,
  input  logic       od_bit,
  input  logic       side_bit,
  input  logic       supply_ok,
  input  logic       ot_trip,
  output drv_state_e state,
  output logic       od_side,
  output logic       ldo_en
);
  localparam int CNT_MAX = (WAKE_CYC > SHUT_CYC) ? WAKE_CYC : SHUT_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] SHUT_LAST = CW'(SHUT_CYC - 1);

  drv_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          permit;
  logic          go;

  assign permit = pwr_bit & supply_ok & ~ot_trip;
  assign go     = permit & en_s;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_OFF: begin
        cnt_d = '0;
        if (go) st_d = ST_WAKING;
      end
      ST_WAKING: begin
        if (!go) begin
          st_d  = ST_OFF;
          cnt_d = '0;
        end else if (cnt_q == WAKE_LAST) begin
          st_d  = ST_DRIVE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_DRIVE, ST_ODRIVE: begin
        if (!permit) begin
          st_d  = ST_OFF;
          cnt_d = '0;
        end else if (!en_s) begin
          if (cnt_q == SHUT_LAST) begin
            st_d  = ST_OFF;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end else begin
          cnt_d = '0;
          st_d  = od_bit ? ST_ODRIVE : ST_DRIVE;
        end
      end
      default: begin
        st_d  = ST_OFF;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state   = st_q;
  assign od_side = (st_q == ST_ODRIVE) & side_bit;
  assign ldo_en  = (st_q != ST_OFF);

  // R6, R8, R9
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |=> (st_q == ST_OFF));

  // R2
  off_exit_only_to_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_WAKING));

  // R5
  od_entry_from_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_ODRIVE) |-> ($past(st_q) == ST_DRIVE));

  // R2
  wake_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAKING) |-> (cnt_q <= WAKE_LAST));

  // R3
  drive_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRIVE || st_q == ST_ODRIVE) && en_s && permit)
      |=> (st_q == ST_DRIVE || st_q == ST_ODRIVE));
endmodule

// File: rtl/erm_drive_ctrl.sv
module erm_drive_ctrl
  import erm_pkg::*;
#(
  parameter int WAKE_CYC = 12500,
  parameter int SHUT_CYC = 250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_pin,
  input  logic [7:0]          ctl0,
  input  logic                uv_ok,
  input  logic                ldo_ok,
  input  logic                ot_flag,
  output logic [1:0]          drive_state,
  output logic                od_side,
  output logic                ldo_en,
  output logic [STATUS_W-1:0] status
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0110;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;
  drv_state_e       st;
  logic [4:0]       ctl_rsvd_unused;

  assign raw_in          = {ot_flag, ldo_ok, uv_ok, en_pin};
  assign ctl_rsvd_unused = ctl0[4:0];

  erm_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (syn)
  );

  erm_drive_fsm #(.WAKE_CYC(WAKE_CYC), .SHUT_CYC(SHUT_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (syn[0]),
    .pwr_bit   (ctl0[CTL_PWR_BIT]),
    .od_bit    (ctl0[CTL_OD_BIT]),
    .side_bit  (ctl0[CTL_SIDE_BIT]),
    .supply_ok (syn[1]),
    .ot_trip   (syn[3]),
    .state     (st),
    .od_side   (od_side),
    .ldo_en    (ldo_en)
  );

  erm_status_pack u_stat (
    .supply_ok (syn[1]),
    .reg_ok    (syn[2]),
    .ot_trip   (syn[3]),
    .status    (status)
  );

  assign drive_state = st;

  // R5
  side_quiet_outside_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_state != 2'b11) |-> !od_side);

  // R7
  status_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:4] == 4'b0000) && !status[0]);
endmodule

// File: tb/sim_erm_drive_ctrl.sv
module sim_erm_drive_ctrl;
  localparam int W = 20;
  localparam int S = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_pin = 1'b0;
  logic [7:0] ctl0 = 8'h90;
  logic       uv_ok = 1'b1;
  logic       ldo_ok = 1'b1;
  logic       ot_flag = 1'b0;
  logic [1:0] drive_state;
  logic       od_side;
  logic       ldo_en;
  logic [7:0] status;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  int         q_at[$];
  logic [11:0] q_val[$];
  string      q_tag[$];

  localparam logic [1:0] OFF = 2'b00, WAK = 2'b01, DRV = 2'b10, ODR = 2'b11;

  erm_drive_ctrl #(.WAKE_CYC(W), .SHUT_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .ctl0(ctl0),
    .uv_ok(uv_ok), .ldo_ok(ldo_ok), .ot_flag(ot_flag),
    .drive_state(drive_state), .od_side(od_side), .ldo_en(ldo_en),
    .status(status)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver side: queue an expected output set at cycle cyc+dt
  task automatic expect_at(input int dt, input logic [1:0] st, input logic side,
                           input logic ldo, input logic [7:0] stat, input string tag);
    q_at.push_back(cyc + dt);
    q_val.push_back({st, side, ldo, stat});
    q_tag.push_back(tag);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_at.size() != 0) @(negedge clk);
    step();
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q_at.size() != 0 && q_at[0] <= cyc) begin
      logic [11:0] act;
      act = {drive_state, od_side, ldo_en, status};
      checks++;
      if (q_at[0] != cyc || act !== q_val[0]) begin
        failures++;
        $display("FAIL %s cyc=%0d actual=%03h expected=%03h", q_tag[0], cyc, act, q_val[0]);
      end
      void'(q_at.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    expect_at(1, OFF, 0, 0, 8'h0E, "R1 reset state");
    drain();

    // wake-up
    en_pin = 1'b1;
    expect_at(2, OFF, 0, 0, 8'h0E, "R10 enable still in synchronizer");
    expect_at(3, WAK, 0, 1, 8'h0E, "R2 R4 waking");
    expect_at(2 + W, WAK, 0, 1, 8'h0E, "R2 still waking");
    expect_at(3 + W, DRV, 0, 1, 8'h0E, "R2 drive after wake count");
    drain();

    // over-drive, positive side
    ctl0 = 8'hF0;
    expect_at(1, ODR, 1, 1, 8'h0E, "R5 over-drive positive");
    drain();
    ctl0 = 8'hD0;
    expect_at(1, ODR, 0, 1, 8'h0E, "R5 over-drive negative");
    drain();
    ctl0 = 8'h90;
    expect_at(1, DRV, 0, 1, 8'h0E, "R5 back to drive");
    drain();

    // regulator flag only affects status
    ldo_ok = 1'b0;
    expect_at(1, DRV, 0, 1, 8'h0E, "R10 regulator flag delay");
    expect_at(2, DRV, 0, 1, 8'h0A, "R7 regulator invalid bit2");
    drain();
    ldo_ok = 1'b1;
    expect_at(2, DRV, 0, 1, 8'h0E, "R7 regulator valid again");
    drain();

    // short low glitch shorter than shutdown delay
    en_pin = 1'b0;
    expect_at(S + 4, DRV, 0, 1, 8'h0E, "R3 short low pulse ignored");
    repeat (3) step();
    en_pin = 1'b1;
    drain();

    // real shutdown
    en_pin = 1'b0;
    expect_at(1 + S, DRV, 0, 1, 8'h0E, "R3 drive held during shutdown delay");
    expect_at(2 + S, OFF, 0, 0, 8'h0E, "R3 R4 off after shutdown delay");
    drain();

    // abort during waking
    en_pin = 1'b1;
    expect_at(3, WAK, 0, 1, 8'h0E, "R3 waking before abort");
    expect_at(7, WAK, 0, 1, 8'h0E, "R3 waking until fall synchronized");
    expect_at(8, OFF, 0, 0, 8'h0E, "R3 fall in waking returns off");
    expect_at(3 + W, OFF, 0, 0, 8'h0E, "R3 drive never reached");
    repeat (5) step();
    en_pin = 1'b0;
    drain();

    // power-down blocks wake
    ctl0 = 8'h10;
    en_pin = 1'b1;
    expect_at(3, OFF, 0, 0, 8'h0E, "R6 power-down blocks wake");
    expect_at(3 + W, OFF, 0, 0, 8'h0E, "R6 power-down still off");
    drain();
    ctl0 = 8'h90;
    expect_at(1, WAK, 0, 1, 8'h0E, "R6 wake after power enable");
    expect_at(1 + W, DRV, 0, 1, 8'h0E, "R6 drive after power enable");
    drain();
    ctl0 = 8'h10;
    expect_at(1, OFF, 0, 0, 8'h0E, "R6 power-down from drive is immediate");
    drain();
    ctl0 = 8'h90;
    expect_at(1 + W, DRV, 0, 1, 8'h0E, "R6 drive restored");
    drain();

    // over-temperature
    ot_flag = 1'b1;
    expect_at(1, DRV, 0, 1, 8'h0E, "R10 temperature flag delay");
    expect_at(2, DRV, 0, 1, 8'h0C, "R7 temperature bit1 low");
    expect_at(3, OFF, 0, 0, 8'h0C, "R8 over-temperature forces off");
    drain();
    ot_flag = 1'b0;
    expect_at(2, OFF, 0, 0, 8'h0E, "R8 flag cleared");
    expect_at(3, WAK, 0, 1, 8'h0E, "R8 rewake after clear");
    expect_at(3 + W, DRV, 0, 1, 8'h0E, "R8 drive resumed");
    drain();

    // under-voltage
    uv_ok = 1'b0;
    expect_at(2, DRV, 0, 1, 8'h06, "R7 supply bit3 low");
    expect_at(3, OFF, 0, 0, 8'h06, "R9 under-voltage forces off");
    expect_at(3 + W, OFF, 0, 0, 8'h06, "R9 wake blocked under-voltage");
    drain();
    uv_ok = 1'b1;
    expect_at(3, WAK, 0, 1, 8'h0E, "R9 rewake after supply valid");
    expect_at(3 + W, DRV, 0, 1, 8'h0E, "R9 drive resumed");
    drain();

    // over-drive shutdown delay and fault
    ctl0 = 8'hF0;
    expect_at(1, ODR, 1, 1, 8'h0E, "R5 over-drive again");
    drain();
    en_pin = 1'b0;
    expect_at(1 + S, ODR, 1, 1, 8'h0E, "R3 over-drive held during delay");
    expect_at(2 + S, OFF, 0, 0, 8'h0E, "R3 over-drive shutdown");
    drain();
    en_pin = 1'b1;
    expect_at(3 + W, DRV, 0, 1, 8'h0E, "R5 wake lands in drive first");
    expect_at(4 + W, ODR, 1, 1, 8'h0E, "R5 then over-drive");
    drain();
    ot_flag = 1'b1;
    expect_at(2, ODR, 1, 1, 8'h0C, "R8 over-drive before fault reaches state");
    expect_at(3, OFF, 0, 0, 8'h0C, "R8 over-drive fault off");
    drain();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule